// File: doc/BRIEF.md
# Halfword Multiply Accumulator

This block keeps a 64-bit signed accumulator and updates it with signed 16x16 multiplies taken from either the upper or the lower halfword of two 32-bit operands. A product is moved 16 bits to the left before it lands in the accumulator. It either replaces the accumulator contents (multiply) or is added to them (multiply-accumulate). A round-and-saturate operation turns the accumulator into a 16.16-style value that sits in the upper word. Read and write operations move 32-bit slices between the accumulator and the operand and result buses.

A host issues one operation per cycle by raising `op_valid_i` together with `op_i`, `opa_i` and `opb_i`. Operations execute strictly in issue order. Back-to-back issue is allowed. Parameter `IN_REG` chooses between two variants:
- With `IN_REG`=1, an input register stage is added. The controller state moves from `ST_IDLE` to `ST_EXEC` on an accepted strobe. It returns to `ST_IDLE` when no strobe follows, and stays in `ST_EXEC` while strobes keep arriving. The operation executes while in `ST_EXEC`.
- With `IN_REG`=0, the operation executes in the same cycle as the strobe.

Top module: `dacc_unit`

## Requirements
- R1: A synchronous reset (`rst_i` high at a clock edge) clears the accumulator, `rd_data_o` and `rd_valid_o` to zero.
- R2: MUL_HI (op code 1) multiplies `opa_i[31:16]` by `opb_i[31:16]` as signed 16-bit values. The 32-bit product is sign-extended to 64 bits, shifted left by 16 and replaces the accumulator.
- R3: MUL_LO (op code 2) does the same using `opa_i[15:0]` and `opb_i[15:0]`.
- R4: MAC_HI (op code 3) and MAC_LO (op code 4) add the shifted product of R2 or R3 to the accumulator. The sum wraps modulo 2^64 and is not saturated.
- R5: RND (op code 5) shifts the accumulator left by 2 if `opa_i[1]` is set, otherwise by 1. It then adds 0x0000000080000000. An in-range result has its low 32 bits cleared.
- R6: During RND, a signed sum above 0x00007FFF00000000 becomes 0x00007FFF00000000, and a signed sum below 0xFFFF800000000000 becomes 0xFFFF800000000000.
- R7: RD_HI (op code 6), RD_MID (op code 7) and RD_LO (op code 8) copy accumulator bits 63:32, 47:16 or 31:0 into `rd_data_o`. They pulse `rd_valid_o` for one cycle and leave the accumulator unchanged.
- R8: WR_HI (op code 9) loads accumulator bits 63:32 from `opa_i`, and WR_LO (op code 10) loads bits 31:0. The other half keeps its value.
- R9: Op code 0 and codes 11 to 15, and any cycle with `op_valid_i` low, change neither the accumulator nor `rd_data_o`.
- R10: The accumulator shows the result of an operation one clock edge after the strobe edge when `IN_REG`=0, and two edges after it when `IN_REG`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| op_valid_i | input | 1 | Operation strobe |
| op_i | input | 4 | Operation code |
| opa_i | input | 32 | First operand (also write data and round shift select) |
| opb_i | input | 32 | Second operand |
| rd_data_o | output | 32 | Last read-back slice |
| rd_valid_o | output | 1 | One-cycle pulse when rd_data_o is updated |
| acc_o | output | 64 | Accumulator state |

## Verification
The bench builds two copies side by side: one with `IN_REG`=1 (registered issue) and one with `IN_REG`=0 (same-cycle issue). Both copies get the same stimulus and are compared against one model. Having the two variants together lets a single check show the one-edge difference in latency. It also shows that both variants give identical results for multiplies, wrapping accumulates, rounds that hit the exact limits or go past them, and the three read views.

// File: rtl/dacc_pkg.sv
package dacc_pkg;

    typedef enum logic [3:0] {
        OP_NOP    = 4'd0,
        OP_MUL_HI = 4'd1,
        OP_MUL_LO = 4'd2,
        OP_MAC_HI = 4'd3,
        OP_MAC_LO = 4'd4,
        OP_RND    = 4'd5,
        OP_RD_HI  = 4'd6,
        OP_RD_MID = 4'd7,
        OP_RD_LO  = 4'd8,
        OP_WR_HI  = 4'd9,
        OP_WR_LO  = 4'd10
    } dacc_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EXEC = 1'b1
    } dacc_state_e;

endpackage

// File: rtl/dacc_halfmul.sv
module dacc_halfmul #(
    parameter int DATA_W = 32,
    parameter int ACC_W  = 64
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              sel_hi_i,
    output logic [ACC_W-1:0]  prod_o
);
    localparam int HALF_W = DATA_W / 2;
    localparam int PROD_W = 2 * HALF_W;
    localparam int EXT_W  = ACC_W - PROD_W;

    logic signed [HALF_W-1:0] ha, hb;
    logic signed [PROD_W-1:0] prod;
    logic        [ACC_W-1:0]  prod_ext;

    always_comb begin
        ha       = sel_hi_i ? a_i[DATA_W-1:HALF_W] : a_i[HALF_W-1:0];
        hb       = sel_hi_i ? b_i[DATA_W-1:HALF_W] : b_i[HALF_W-1:0];
        prod     = ha * hb;
        prod_ext = {{EXT_W{prod[PROD_W-1]}}, prod};
        prod_o   = prod_ext << HALF_W;
    end
endmodule

// File: rtl/dacc_rndsat.sv
module dacc_rndsat #(
    parameter int              ACC_W  = 64,
    parameter int              DATA_W = 32,
    parameter logic [ACC_W-1:0] LIM_HI = '0,
    parameter logic [ACC_W-1:0] LIM_LO = '0
) (
    input  logic [ACC_W-1:0] acc_i,
    input  logic             shift2_i,
    output logic [ACC_W-1:0] res_o
);
    localparam logic [ACC_W-1:0] BIAS     = ACC_W'(1) << (DATA_W - 1);
    localparam logic [ACC_W-1:0] LOW_MASK = (ACC_W'(1) << DATA_W) - ACC_W'(1);

    logic [ACC_W-1:0] shifted, biased;

    always_comb begin
        shifted = shift2_i ? (acc_i << 2) : (acc_i << 1);
        biased  = shifted + BIAS;
        if ($signed(biased) > $signed(LIM_HI))
            res_o = LIM_HI;
        else if ($signed(biased) < $signed(LIM_LO))
            res_o = LIM_LO;
        else
            res_o = biased & ~LOW_MASK;
    end
endmodule

// File: rtl/dacc_view.sv
module dacc_view
    import dacc_pkg::*;
#(
    parameter int ACC_W  = 64,
    parameter int DATA_W = 32
) (
    input  logic [ACC_W-1:0]  acc_i,
    input  dacc_op_e          op_i,
    output logic              hit_o,
    output logic [DATA_W-1:0] data_o
);
    localparam int HALF_W = DATA_W / 2;

    always_comb begin
        hit_o  = 1'b1;
        data_o = '0;
        unique case (op_i)
            OP_RD_HI:  data_o = acc_i[ACC_W-1 -: DATA_W];
            OP_RD_MID: data_o = acc_i[HALF_W +: DATA_W];
            OP_RD_LO:  data_o = acc_i[DATA_W-1:0];
            default:   hit_o  = 1'b0;
        endcase
    end
endmodule

// File: rtl/dacc_unit.sv
module dacc_unit
    import dacc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ACC_W  = 64,
    parameter bit IN_REG = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              op_valid_i,
    input  logic [3:0]        op_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_valid_o,
    output logic [ACC_W-1:0]  acc_o
);
    localparam int HALF_W = DATA_W / 2;
    localparam logic [ACC_W-1:0] LIM_HI =
        ((ACC_W'(1) << (HALF_W - 1)) - ACC_W'(1)) << DATA_W;
    localparam logic [ACC_W-1:0] LIM_LO =
        ~((ACC_W'(1) << (HALF_W - 1 + DATA_W)) - ACC_W'(1));

    dacc_state_e       state_q, state_d;
    logic              ex_vld;
    dacc_op_e          ex_op;
    logic [DATA_W-1:0] ex_a, ex_b;

    logic [ACC_W-1:0]  acc_q, acc_d;
    logic [ACC_W-1:0]  prod_sh, rnd_res;
    logic              rd_hit;
    logic [DATA_W-1:0] rd_view;
    logic              sel_hi;

    // Issue controller: tracks whether an operation sits in the execute slot
    always_comb begin
        state_d = op_valid_i ? ST_EXEC : ST_IDLE;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= ST_IDLE;
        else       state_q <= state_d;
    end

    generate
        if (IN_REG) begin : g_reg_issue
            dacc_op_e          op_q;
            logic [DATA_W-1:0] a_q, b_q;
            always_ff @(posedge clk_i) begin
                if (rst_i) begin
                    op_q <= OP_NOP;
                    a_q  <= '0;
                    b_q  <= '0;
                end else if (op_valid_i) begin
                    op_q <= dacc_op_e'(op_i);
                    a_q  <= opa_i;
                    b_q  <= opb_i;
                end
            end
            assign ex_vld = (state_q == ST_EXEC);
            assign ex_op  = op_q;
            assign ex_a   = a_q;
            assign ex_b   = b_q;
        end else begin : g_direct_issue
            assign ex_vld = op_valid_i;
            assign ex_op  = dacc_op_e'(op_i);
            assign ex_a   = opa_i;
            assign ex_b   = opb_i;
        end
    endgenerate

    assign sel_hi = (ex_op == OP_MUL_HI) || (ex_op == OP_MAC_HI);

    dacc_halfmul #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_mul (
        .a_i      (ex_a),
        .b_i      (ex_b),
        .sel_hi_i (sel_hi),
        .prod_o   (prod_sh)
    );

    dacc_rndsat #(.ACC_W(ACC_W), .DATA_W(DATA_W), .LIM_HI(LIM_HI), .LIM_LO(LIM_LO)) u_rnd (
        .acc_i    (acc_q),
        .shift2_i (ex_a[1]),
        .res_o    (rnd_res)
    );

    dacc_view #(.ACC_W(ACC_W), .DATA_W(DATA_W)) u_view (
        .acc_i  (acc_q),
        .op_i   (ex_op),
        .hit_o  (rd_hit),
        .data_o (rd_view)
    );

    // Output process: next accumulator value per executed operation
    always_comb begin
        acc_d = acc_q;
        if (ex_vld) begin
            unique case (ex_op)
                OP_MUL_HI, OP_MUL_LO: acc_d = prod_sh;
                OP_MAC_HI, OP_MAC_LO: acc_d = acc_q + prod_sh;
                OP_RND:               acc_d = rnd_res;
                OP_WR_HI:             acc_d = {ex_a, acc_q[DATA_W-1:0]};
                OP_WR_LO:             acc_d = {acc_q[ACC_W-1:DATA_W], ex_a};
                default:              acc_d = acc_q;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            acc_q      <= '0;
            rd_data_o  <= '0;
            rd_valid_o <= 1'b0;
        end else begin
            acc_q      <= acc_d;
            rd_valid_o <= ex_vld && rd_hit;
            if (ex_vld && rd_hit) rd_data_o <= rd_view;
        end
    end

    assign acc_o = acc_q;

    // R1: reset leaves a zero accumulator
    a_r1_reset_clear: assert property (@(posedge clk_i)
        $past(rst_i) |-> (acc_o == '0 && rd_valid_o == 1'b0));

    // R2 / R3: a fresh product always has 16 zero low bits
    a_r2_mul_low_zero: assert property (@(posedge clk_i) disable iff (rst_i)
        (ex_vld && (ex_op == OP_MUL_HI || ex_op == OP_MUL_LO))
        |=> (acc_q[HALF_W-1:0] == '0));

    // R5: round result has a cleared low word
    a_r5_round_low_clear: assert property (@(posedge clk_i) disable iff (rst_i)
        (ex_vld && ex_op == OP_RND) |=> (acc_q[DATA_W-1:0] == '0));

    // R6: round result lies inside the clamp limits
    a_r6_round_in_range: assert property (@(posedge clk_i) disable iff (rst_i)
        (ex_vld && ex_op == OP_RND)
        |=> ($signed(acc_q) <= $signed(LIM_HI) && $signed(acc_q) >= $signed(LIM_LO)));

    // R7: reads never disturb the accumulator
    a_r7_read_keeps_acc: assert property (@(posedge clk_i) disable iff (rst_i)
        (ex_vld && (ex_op == OP_RD_HI || ex_op == OP_RD_MID || ex_op == OP_RD_LO))
        |=> ($stable(acc_q) && rd_valid_o));

    // R8: a high write preserves the low half
    a_r8_write_hi_keeps_lo: assert property (@(posedge clk_i) disable iff (rst_i)
        (ex_vld && ex_op == OP_WR_HI) |=> (acc_q[DATA_W-1:0] == $past(acc_q[DATA_W-1:0])));

    // R9: no execution means no change
    a_r9_idle_stable: assert property (@(posedge clk_i) disable iff (rst_i)
        (!ex_vld) |=> ($stable(acc_q) && $stable(rd_data_o)));
endmodule

// File: tb/dacc_unit_tb_top.sv
module dacc_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        vld;
    logic [3:0]  op;
    logic [31:0] opa, opb;
    logic [31:0] rd_i, rd_s;
    logic        rv_i, rv_s;
    logic [63:0] acc_i, acc_s;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [63:0] model;

    always #2 clk = ~clk;

    dacc_unit #(.IN_REG(1'b1)) dut_i (
        .clk_i(clk), .rst_i(rst), .op_valid_i(vld), .op_i(op), .opa_i(opa), .opb_i(opb),
        .rd_data_o(rd_i), .rd_valid_o(rv_i), .acc_o(acc_i));

    dacc_unit #(.IN_REG(1'b0)) dut_s (
        .clk_i(clk), .rst_i(rst), .op_valid_i(vld), .op_i(op), .opa_i(opa), .opb_i(opb),
        .rd_data_o(rd_s), .rd_valid_o(rv_s), .acc_o(acc_s));

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic chk_acc(input string tag);
        chk({tag, " reg-issue acc"}, acc_i, model);
        chk({tag, " direct acc"}, acc_s, model);
    endtask

    task automatic chk_rd(input string tag, input logic [31:0] exp);
        chk({tag, " reg-issue rd"}, {32'h0, rd_i}, {32'h0, exp});
        chk({tag, " direct rd"}, {32'h0, rd_s}, {32'h0, exp});
    endtask

    task automatic issue(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        vld = 1'b1; op = o; opa = a; opb = b;
        @(negedge clk);
        vld = 1'b0; op = 4'd0; opa = '0; opb = '0;
        @(negedge clk);
        @(negedge clk);
    endtask

    function automatic logic [63:0] m_mul(input logic [31:0] a, input logic [31:0] b, input bit hi);
        logic signed [15:0] x, y;
        longint p;
        x = hi ? a[31:16] : a[15:0];
        y = hi ? b[31:16] : b[15:0];
        p = longint'(x) * longint'(y);
        return 64'(p) << 16;
    endfunction

    function automatic logic [63:0] m_rnd(input logic [63:0] acc, input bit two);
        longint t;
        t = longint'(two ? (acc << 2) : (acc << 1)) + 64'h0000_0000_8000_0000;
        if (t > longint'(64'h0000_7FFF_0000_0000)) return 64'h0000_7FFF_0000_0000;
        if (t < longint'(64'hFFFF_8000_0000_0000)) return 64'hFFFF_8000_0000_0000;
        return 64'(t) & 64'hFFFF_FFFF_0000_0000;
    endfunction

    task automatic set_acc(input logic [63:0] v);
        issue(4'd9, v[63:32], '0);
        issue(4'd10, v[31:0], '0);
        model = v;
    endtask

    task automatic t_reset;
        rst = 1'b1; vld = 1'b0; op = '0; opa = '0; opb = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        model = '0;
        chk_acc("R1 reset");
        chk_rd("R1 reset", 32'h0);
        chk("R1 reset rd_valid", {63'h0, rv_i | rv_s}, 64'h0);
    endtask

    task automatic t_mul;
        issue(4'd1, 32'hFFFE_1234, 32'h0003_ABCD);
        model = 64'hFFFF_FFFF_FFFA_0000;
        chk_acc("R2 mul_hi -2*3");
        issue(4'd1, 32'h7FFF_0000, 32'h8000_0000);
        model = m_mul(32'h7FFF_0000, 32'h8000_0000, 1'b1);
        chk_acc("R2 mul_hi max*min");
        issue(4'd2, 32'h1234_8000, 32'hABCD_8000);
        model = 64'h0000_4000_0000_0000;
        chk_acc("R3 mul_lo -32768^2");
        issue(4'd2, 32'h0000_0005, 32'h0000_FFFD);
        model = m_mul(32'h5, 32'hFFFD, 1'b0);
        chk_acc("R3 mul_lo 5*-3");
    endtask

    task automatic t_mac;
        set_acc(64'h0000_0000_0001_0000);
        issue(4'd3, 32'h0002_0000, 32'h0004_0000);
        model = model + m_mul(32'h0002_0000, 32'h0004_0000, 1'b1);
        chk_acc("R4 mac_hi");
        issue(4'd4, 32'h0000_FFFF, 32'h0000_0007);
        model = model + m_mul(32'hFFFF, 32'h7, 1'b0);
        chk_acc("R4 mac_lo negative");
        set_acc(64'h7FFF_FFFF_FFFF_FFFF);
        issue(4'd4, 32'h1, 32'h1);
        model = 64'h8000_0000_0000_FFFF;
        chk_acc("R4 mac wrap positive to negative");
        set_acc(64'hFFFF_FFFF_FFFF_0000);
        issue(4'd4, 32'h1, 32'h1);
        model = 64'h0;
        chk_acc("R4 mac wrap to zero");
    endtask

    task automatic t_round;
        set_acc(64'h0000_1234_8000_0000);
        issue(4'd5, 32'h1, '0);
        model = m_rnd(64'h0000_1234_8000_0000, 1'b0);
        chk_acc("R5 round shift1");
        set_acc(64'hFFFF_F000_4000_0001);
        issue(4'd5, 32'h2, '0);
        model = m_rnd(64'hFFFF_F000_4000_0001, 1'b1);
        chk_acc("R5 round shift2 negative");
        set_acc(64'h0000_3FFF_4000_0000);
        issue(4'd5, 32'h1, '0);
        model = 64'h0000_7FFF_0000_0000;
        chk_acc("R6 round exactly upper limit");
        set_acc(64'h0000_4000_0000_0000);
        issue(4'd5, 32'h2, '0);
        model = 64'h0000_7FFF_0000_0000;
        chk_acc("R6 clamp upper");
        set_acc(64'hFFFF_C000_0000_0000);
        issue(4'd5, 32'h2, '0);
        model = 64'hFFFF_8000_0000_0000;
        chk_acc("R6 clamp lower");
    endtask

    task automatic t_reads;
        set_acc(64'h1122_3344_5566_7788);
        issue(4'd6, '0, '0);
        chk_rd("R7 read hi", 32'h1122_3344);
        issue(4'd7, '0, '0);
        chk_rd("R7 read mid", 32'h3344_5566);
        issue(4'd8, '0, '0);
        chk_rd("R7 read lo", 32'h5566_7788);
        chk_acc("R7 acc kept after reads");
    endtask

    task automatic t_writes;
        set_acc(64'hAAAA_BBBB_CCCC_DDDD);
        issue(4'd9, 32'h0102_0304, '0);
        model = 64'h0102_0304_CCCC_DDDD;
        chk_acc("R8 write hi");
        issue(4'd10, 32'hF0E0_D0C0, '0);
        model = 64'h0102_0304_F0E0_D0C0;
        chk_acc("R8 write lo");
    endtask

    task automatic t_ignore;
        issue(4'd15, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        chk_acc("R9 undefined code 15");
        issue(4'd0, 32'h1234_5678, 32'h1);
        chk_acc("R9 code 0");
        @(negedge clk);
        vld = 1'b0; op = 4'd1; opa = 32'h0005_0000; opb = 32'h0005_0000;
        repeat (3) @(negedge clk);
        op = 4'd0; opa = '0; opb = '0;
        chk_acc("R9 valid low");
        chk_rd("R9 rd unchanged", 32'h5566_7788);
    endtask

    task automatic t_latency;
        @(negedge clk);
        vld = 1'b1; op = 4'd10; opa = 32'h0BAD_F00D; opb = '0;
        @(negedge clk);
        vld = 1'b0; op = 4'd0; opa = '0;
        chk("R10 direct after one edge", acc_s, {model[63:32], 32'h0BAD_F00D});
        chk("R10 reg-issue not yet after one edge", acc_i, model);
        @(negedge clk);
        model = {model[63:32], 32'h0BAD_F00D};
        chk("R10 reg-issue after two edges", acc_i, model);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        model = '0;
        t_reset();
        t_mul();
        t_mac();
        t_round();
        t_reads();
        t_writes();
        t_ignore();
        t_latency();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule